// File: doc/BRIEF.md
# Privilege-Banked General Register File

This block is a 32-bit general register file with sixteen architectural registers. Indices 0 to 7 are backed by two physical banks. Indices 8 to 15 have a single copy that every mode shares. A privilege flag and a bank flag, both held in the block's status word, decide which bank the two read ports and the one write port reach. A separate alternate port reaches the bank that is currently hidden. It serves privileged move-to-bank and move-from-bank operations.

The block also holds eight control words: global base, status, saved status, saved return address, vector base, multiply-accumulate high and low, and the return-link word. It checks every control access and every alternate-port access against the current privilege. It raises a violation flag in the same cycle as any access the mode does not allow, and a rejected access changes nothing. An exception-taken pulse forces privileged mode and bank 1.

All ports are plain. Reads are combinational and writes commit on the clock edge. Every request is accepted in the cycle it is presented, so there is no back-pressure.

Top module: `bankreg_file`

## Requirements
- R1: After reset, every general and control register reads zero, except the status word, which reads 0x6000_0000. Bit 30 is the privilege flag and bit 29 is the bank flag. So the block starts privileged (`priv_o`=1) on bank 1 (`bank_o`=1).
- R2: In privileged mode with the bank flag at 1, indices 0 to 7 on the read and write ports reach bank 1, and the alternate port reaches bank 0.
- R3: In privileged mode with the bank flag at 0, indices 0 to 7 on the read and write ports reach bank 0, and the alternate port reaches bank 1.
- R4: In user mode, indices 0 to 7 reach bank 0 whatever the bank flag holds. Any alternate-port read or write raises `viol_o`. The rejected read returns zero, and the rejected write modifies nothing.
- R5: Indices 8 to 15 reach one shared copy in every mode and with either bank flag.
- R6: Control selector codes are 0 global base, 1 status, 5 multiply-accumulate high, 6 multiply-accumulate low and 7 return link. These can be read and written in both modes without raising `viol_o`.
- R7: Control selector codes 2 (saved status), 3 (saved return address) and 4 (vector base) are privileged only. A user-mode access raises `viol_o`, reads zero and modifies nothing.
- R8: A user-mode write to the status word updates every bit except bits 30 and 29, which keep their values.
- R9: A privileged write to the status word may change bits 30 and 29. `priv_o` and `bank_o` follow from the next cycle.
- R10: `exc_take_i` sets the privilege and bank flags from the next cycle. It suppresses any status-word write in the same cycle and leaves the other status bits unchanged.
- R11: A read of the register being written in the same cycle returns the old value. The new value appears from the next cycle.
- R12: `viol_o` is high only in a cycle that presents a rejected access and is low in every other cycle. Privileged mode never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx_i | input | 4 | Read port A architectural index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B architectural index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General write enable |
| wr_idx_i | input | 4 | General write index |
| wr_data_i | input | 32 | General write data |
| alt_rd_en_i | input | 1 | Alternate-bank read request |
| alt_wr_en_i | input | 1 | Alternate-bank write request |
| alt_idx_i | input | 3 | Alternate-bank index (0 to 7) |
| alt_wr_data_i | input | 32 | Alternate-bank write data |
| alt_rd_data_o | output | 32 | Alternate-bank read data |
| ctl_rd_en_i | input | 1 | Control register read request |
| ctl_wr_en_i | input | 1 | Control register write request |
| ctl_sel_i | input | 3 | Control register selector |
| ctl_wr_data_i | input | 32 | Control write data |
| ctl_rd_data_o | output | 32 | Control read data |
| exc_take_i | input | 1 | Exception or interrupt taken pulse |
| priv_o | output | 1 | Current privilege flag |
| bank_o | output | 1 | Current bank flag |
| viol_o | output | 1 | Access violation in this cycle |

## Verification
The hardest case to reach is a rejected alternate-port write in user mode while the bank flag still reads 1. To show that nothing changed, the bench has to leave user mode and read the hidden bank back.

The stimulus first fills both banks through privileged writes under each bank setting. It then drops to user mode through a privileged status write that keeps the bank flag at 1. In user mode it issues the rejected writes, then returns to privileged mode with an exception pulse. Finally it reads both copies of index 3 and the saved status word, comparing them with the values written before the rejected accesses.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

  // Status word flag positions
  localparam int STAT_PRIV_BIT = 30;
  localparam int STAT_BANK_BIT = 29;

  typedef enum logic [2:0] {
    CS_GBASE   = 3'd0,
    CS_STAT    = 3'd1,
    CS_SAVSTAT = 3'd2,
    CS_SAVPC   = 3'd3,
    CS_VECBASE = 3'd4,
    CS_MACHI   = 3'd5,
    CS_MACLO   = 3'd6,
    CS_RETLINK = 3'd7
  } ctl_sel_e;

  function automatic logic sel_is_privileged(input logic [2:0] sel);
    return (sel == CS_SAVSTAT) || (sel == CS_SAVPC) || (sel == CS_VECBASE);
  endfunction

endpackage

// File: rtl/bankreg_map.sv
// Translates an index into a physical slot.
// Layout: bank 0 slots 0..NB-1, bank 1 slots NB..2NB-1, shared slots above.
module bankreg_map #(
  parameter int NUM_ARCH   = 16,
  parameter int NUM_BANKED = 8,
  parameter int IN_W       = 4,
  parameter int PHYS_W     = 5,
  parameter bit ALT_PATH   = 1'b0
) (
  input  logic              priv_i,
  input  logic              bank_i,
  input  logic [IN_W-1:0]   idx_i,
  output logic [PHYS_W-1:0] phys_o
);

  localparam logic [PHYS_W-1:0] BANK_OFS = PHYS_W'(NUM_BANKED);

  generate
    if (ALT_PATH) begin : g_alt
      // Hidden bank: bank 0 when the bank flag is set, else bank 1
      always_comb begin
        phys_o = PHYS_W'(idx_i) + (bank_i ? '0 : BANK_OFS);
      end
    end else begin : g_norm
      logic use_b1;
      assign use_b1 = priv_i & bank_i;
      always_comb begin
        if (PHYS_W'(idx_i) < BANK_OFS)
          phys_o = PHYS_W'(idx_i) + (use_b1 ? BANK_OFS : '0);
        else
          phys_o = PHYS_W'(idx_i) + BANK_OFS;
      end
    end
  endgenerate

endmodule

// File: rtl/bankreg_store.sv
// Physical storage: NRD combinational reads, two write ports (port 0 wins).
module bankreg_store #(
  parameter int DATA_W   = 32,
  parameter int NUM_PHYS = 24,
  parameter int NRD      = 3,
  localparam int PHYS_W  = $clog2(NUM_PHYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHYS_W-1:0] rd_addr_i [NRD],
  output logic [DATA_W-1:0] rd_data_o [NRD],
  input  logic              w0_en_i,
  input  logic [PHYS_W-1:0] w0_addr_i,
  input  logic [DATA_W-1:0] w0_data_i,
  input  logic              w1_en_i,
  input  logic [PHYS_W-1:0] w1_addr_i,
  input  logic [DATA_W-1:0] w1_data_i
);

  logic [DATA_W-1:0] regs_q [NUM_PHYS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_PHYS; i++) begin
      if (!rst_n)
        regs_q[i] <= '0;
      else if (w0_en_i && (w0_addr_i == PHYS_W'(i)))
        regs_q[i] <= w0_data_i;
      else if (w1_en_i && (w1_addr_i == PHYS_W'(i)))
        regs_q[i] <= w1_data_i;
    end
  end

  generate
    for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rd_data_o[p] = regs_q[rd_addr_i[p]];
    end
  endgenerate

endmodule

// File: rtl/bankreg_ctrl.sv
// Control words with privilege checking; owns the privilege and bank flags.
module bankreg_ctrl
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CTL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [2:0]        sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              exc_take_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              viol_o,
  output logic              priv_o,
  output logic              bank_o
);

  localparam logic [DATA_W-1:0] FLAG_MASK =
    (DATA_W'(1) << STAT_PRIV_BIT) | (DATA_W'(1) << STAT_BANK_BIT);

  logic [DATA_W-1:0] ctl_q [NUM_CTL];
  logic              denied;
  logic              wr_ok;
  logic [DATA_W-1:0] stat_next;

  assign priv_o = ctl_q[CS_STAT][STAT_PRIV_BIT];
  assign bank_o = ctl_q[CS_STAT][STAT_BANK_BIT];

  assign denied = !priv_o && sel_is_privileged(sel_i);
  assign viol_o = (rd_en_i || wr_en_i) && denied;
  assign wr_ok  = wr_en_i && !denied;

  // In user mode the flag bits of the status word are protected
  always_comb begin
    if (priv_o)
      stat_next = wr_data_i;
    else
      stat_next = (wr_data_i & ~FLAG_MASK) | (ctl_q[CS_STAT] & FLAG_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CTL; i++) begin
        ctl_q[i] <= (i == int'(CS_STAT)) ? FLAG_MASK : '0;
      end
    end else begin
      if (exc_take_i) begin
        ctl_q[CS_STAT] <= ctl_q[CS_STAT] | FLAG_MASK;
      end else if (wr_ok && (sel_i == CS_STAT)) begin
        ctl_q[CS_STAT] <= stat_next;
      end
      if (wr_ok && (sel_i != CS_STAT)) begin
        ctl_q[sel_i] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = (rd_en_i && !denied) ? ctl_q[sel_i] : '0;

endmodule

// File: rtl/bankreg_file.sv
module bankreg_file #(
  parameter int DATA_W     = 32,
  parameter int NUM_ARCH   = 16,
  parameter int NUM_BANKED = 8,
  localparam int IDX_W     = $clog2(NUM_ARCH),
  localparam int ALT_W     = $clog2(NUM_BANKED),
  localparam int NUM_PHYS  = NUM_ARCH + NUM_BANKED,
  localparam int PHYS_W    = $clog2(NUM_PHYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              alt_rd_en_i,
  input  logic              alt_wr_en_i,
  input  logic [ALT_W-1:0]  alt_idx_i,
  input  logic [DATA_W-1:0] alt_wr_data_i,
  output logic [DATA_W-1:0] alt_rd_data_o,
  input  logic              ctl_rd_en_i,
  input  logic              ctl_wr_en_i,
  input  logic [2:0]        ctl_sel_i,
  input  logic [DATA_W-1:0] ctl_wr_data_i,
  output logic [DATA_W-1:0] ctl_rd_data_o,
  input  logic              exc_take_i,
  output logic              priv_o,
  output logic              bank_o,
  output logic              viol_o
);

  localparam int NRD = 3;

  logic              priv, bank;
  logic              ctl_viol, alt_viol;
  logic [PHYS_W-1:0] rd_addr [NRD];
  logic [DATA_W-1:0] rd_data [NRD];
  logic [PHYS_W-1:0] wr_phys, alt_phys;
  logic [IDX_W-1:0]  norm_idx [2];

  assign norm_idx[0] = rd_a_idx_i;
  assign norm_idx[1] = rd_b_idx_i;

  bankreg_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en_i   (ctl_rd_en_i),
    .wr_en_i   (ctl_wr_en_i),
    .sel_i     (ctl_sel_i),
    .wr_data_i (ctl_wr_data_i),
    .exc_take_i(exc_take_i),
    .rd_data_o (ctl_rd_data_o),
    .viol_o    (ctl_viol),
    .priv_o    (priv),
    .bank_o    (bank)
  );

  generate
    for (genvar r = 0; r < 2; r++) begin : g_rdmap
      bankreg_map #(
        .NUM_ARCH(NUM_ARCH), .NUM_BANKED(NUM_BANKED),
        .IN_W(IDX_W), .PHYS_W(PHYS_W), .ALT_PATH(1'b0)
      ) u_map (
        .priv_i(priv), .bank_i(bank), .idx_i(norm_idx[r]), .phys_o(rd_addr[r])
      );
    end
  endgenerate

  bankreg_map #(
    .NUM_ARCH(NUM_ARCH), .NUM_BANKED(NUM_BANKED),
    .IN_W(IDX_W), .PHYS_W(PHYS_W), .ALT_PATH(1'b0)
  ) u_wrmap (
    .priv_i(priv), .bank_i(bank), .idx_i(wr_idx_i), .phys_o(wr_phys)
  );

  bankreg_map #(
    .NUM_ARCH(NUM_ARCH), .NUM_BANKED(NUM_BANKED),
    .IN_W(ALT_W), .PHYS_W(PHYS_W), .ALT_PATH(1'b1)
  ) u_altmap (
    .priv_i(priv), .bank_i(bank), .idx_i(alt_idx_i), .phys_o(alt_phys)
  );

  assign rd_addr[2] = alt_phys;

  bankreg_store #(.DATA_W(DATA_W), .NUM_PHYS(NUM_PHYS), .NRD(NRD)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .w0_en_i   (wr_en_i),
    .w0_addr_i (wr_phys),
    .w0_data_i (wr_data_i),
    .w1_en_i   (alt_wr_en_i && priv),
    .w1_addr_i (alt_phys),
    .w1_data_i (alt_wr_data_i)
  );

  assign alt_viol      = (alt_rd_en_i || alt_wr_en_i) && !priv;
  assign rd_a_data_o   = rd_data[0];
  assign rd_b_data_o   = rd_data[1];
  assign alt_rd_data_o = (alt_rd_en_i && priv) ? rd_data[2] : '0;
  assign priv_o        = priv;
  assign bank_o        = bank;
  assign viol_o        = ctl_viol || alt_viol;

endmodule

// File: rtl/bankreg_chk.sv
module bankreg_chk #(
  parameter int DATA_W     = 32,
  parameter int NUM_ARCH   = 16,
  parameter int NUM_BANKED = 8,
  localparam int IDX_W     = $clog2(NUM_ARCH),
  localparam int ALT_W     = $clog2(NUM_BANKED)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W-1:0]  rd_a_idx_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic              wr_en_i,
  input logic [IDX_W-1:0]  wr_idx_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              alt_rd_en_i,
  input logic              alt_wr_en_i,
  input logic [ALT_W-1:0]  alt_idx_i,
  input logic [DATA_W-1:0] alt_rd_data_o,
  input logic              ctl_rd_en_i,
  input logic              ctl_wr_en_i,
  input logic [2:0]        ctl_sel_i,
  input logic              exc_take_i,
  input logic              priv_o,
  input logic              bank_o,
  input logic              viol_o
);

  p_user_alt_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_o && (alt_rd_en_i || alt_wr_en_i)) |-> viol_o);

  p_user_alt_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_o && alt_rd_en_i) |-> (alt_rd_data_o == '0));

  p_user_flags_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_o && ctl_wr_en_i && ctl_sel_i == 3'd1 && !exc_take_i)
      |=> (!priv_o && bank_o == $past(bank_o)));

  p_exc_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take_i |=> (priv_o && bank_o));

  p_old_then_new_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && rd_a_idx_i == wr_idx_i && !ctl_wr_en_i && !exc_take_i)
      |=> (rd_a_idx_i != $past(rd_a_idx_i) || rd_a_data_o == $past(wr_data_i)));

  p_priv_no_viol_r12: assert property (@(posedge clk) disable iff (!rst_n)
    priv_o |-> !viol_o);

  p_viol_needs_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> (alt_rd_en_i || alt_wr_en_i || ctl_rd_en_i || ctl_wr_en_i));

  // alt_idx_i is listed for completeness of the bound view
  wire unused_ok = &{1'b0, alt_idx_i};

endmodule

bind bankreg_file bankreg_chk #(
  .DATA_W(DATA_W), .NUM_ARCH(NUM_ARCH), .NUM_BANKED(NUM_BANKED)
) u_chk (.*);

// File: tb/bankreg_file_bench.sv
module bankreg_file_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_a_idx_i, rd_b_idx_i, wr_idx_i;
  logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i;
  logic        wr_en_i, alt_rd_en_i, alt_wr_en_i;
  logic [2:0]  alt_idx_i;
  logic [31:0] alt_wr_data_i, alt_rd_data_o;
  logic        ctl_rd_en_i, ctl_wr_en_i;
  logic [2:0]  ctl_sel_i;
  logic [31:0] ctl_wr_data_i, ctl_rd_data_o;
  logic        exc_take_i, priv_o, bank_o, viol_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  bankreg_file u_bankreg_file (.*);

  // Observed outputs
  localparam int W_RDA = 0, W_RDB = 1, W_ALT = 2, W_CTL = 3,
                 W_VIOL = 4, W_PRIV = 5, W_BANK = 6;

  typedef struct {
    string       req;
    int          what;
    logic [31:0] exp;
  } item_t;

  item_t sbq[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  // Monitor: compares pending expectations away from the active edge
  always @(negedge clk) begin
    item_t       it;
    logic [31:0] got;
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      case (it.what)
        W_RDA:   got = rd_a_data_o;
        W_RDB:   got = rd_b_data_o;
        W_ALT:   got = alt_rd_data_o;
        W_CTL:   got = ctl_rd_data_o;
        W_VIOL:  got = {31'd0, viol_o};
        W_PRIV:  got = {31'd0, priv_o};
        default: got = {31'd0, bank_o};
      endcase
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s: output %0d actual %h expected %h", it.req, it.what, got, it.exp);
      end
    end
  end

  task automatic expect_val(string req, int what, logic [31:0] v);
    item_t it;
    it.req = req; it.what = what; it.exp = v;
    sbq.push_back(it);
  endtask

  task automatic clr();
    rd_a_idx_i = '0; rd_b_idx_i = '0;
    wr_en_i = 1'b0; wr_idx_i = '0; wr_data_i = '0;
    alt_rd_en_i = 1'b0; alt_wr_en_i = 1'b0; alt_idx_i = '0; alt_wr_data_i = '0;
    ctl_rd_en_i = 1'b0; ctl_wr_en_i = 1'b0; ctl_sel_i = '0; ctl_wr_data_i = '0;
    exc_take_i = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    clr();
  endtask

  task automatic gwr(logic [3:0] i, logic [31:0] d);
    wr_en_i = 1'b1; wr_idx_i = i; wr_data_i = d;
  endtask

  task automatic cwr(logic [2:0] s, logic [31:0] d);
    ctl_wr_en_i = 1'b1; ctl_sel_i = s; ctl_wr_data_i = d;
  endtask

  task automatic crd(logic [2:0] s);
    ctl_rd_en_i = 1'b1; ctl_sel_i = s;
  endtask

  task automatic ard(logic [2:0] i);
    alt_rd_en_i = 1'b1; alt_idx_i = i;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    clr();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_a_idx_i = 4'd3; rd_b_idx_i = 4'd12; crd(3'd1);
    expect_val("R1", W_RDA, 0); expect_val("R1", W_RDB, 0);
    expect_val("R1", W_PRIV, 1); expect_val("R1", W_BANK, 1);
    expect_val("R1", W_VIOL, 0); expect_val("R1", W_CTL, 32'h6000_0000);
    tick();

    // R11 same-cycle read sees old value
    gwr(4'd3, 32'h0000_00A1); rd_a_idx_i = 4'd3;
    expect_val("R11", W_RDA, 0);
    tick();

    // R2 bank 1 visible, alternate reaches bank 0
    rd_a_idx_i = 4'd3; ard(3'd3);
    alt_wr_en_i = 1'b1; alt_wr_data_i = 32'h0000_00B0;
    expect_val("R11", W_RDA, 32'hA1); expect_val("R2", W_ALT, 0);
    tick();
    rd_a_idx_i = 4'd3; ard(3'd3); gwr(4'd12, 32'h0000_0C12);
    expect_val("R2", W_RDA, 32'hA1); expect_val("R2", W_ALT, 32'hB0);
    tick();

    // R9 privileged switch to bank 0
    cwr(3'd1, 32'h4000_0000); rd_b_idx_i = 4'd12;
    expect_val("R5", W_RDB, 32'hC12);
    tick();

    // R3 bank 0 visible, alternate reaches bank 1
    rd_a_idx_i = 4'd3; ard(3'd3); cwr(3'd2, 32'h55);
    expect_val("R9", W_BANK, 0); expect_val("R9", W_PRIV, 1);
    expect_val("R3", W_RDA, 32'hB0); expect_val("R3", W_ALT, 32'hA1);
    expect_val("R7", W_VIOL, 0);
    tick();
    crd(3'd2); gwr(4'd3, 32'h33);
    expect_val("R7", W_CTL, 32'h55);
    tick();
    ard(3'd3); rd_a_idx_i = 4'd3; cwr(3'd1, 32'h2000_0000);
    expect_val("R3", W_ALT, 32'hA1); expect_val("R3", W_RDA, 32'h33);
    tick();

    // R4 user mode, bank flag 1 but bank 0 visible
    rd_a_idx_i = 4'd3; rd_b_idx_i = 4'd12; ard(3'd3);
    expect_val("R9", W_PRIV, 0); expect_val("R9", W_BANK, 1);
    expect_val("R4", W_RDA, 32'h33); expect_val("R5", W_RDB, 32'hC12);
    expect_val("R4", W_VIOL, 1); expect_val("R4", W_ALT, 0);
    tick();
    alt_wr_en_i = 1'b1; alt_idx_i = 3'd3; alt_wr_data_i = 32'hDEAD;
    expect_val("R4", W_VIOL, 1);
    tick();

    // R7 privileged-only words in user mode, R12 flag drops
    cwr(3'd2, 32'h99);
    expect_val("R7", W_VIOL, 1);
    tick();
    expect_val("R12", W_VIOL, 0);
    tick();
    crd(3'd2);
    expect_val("R7", W_VIOL, 1); expect_val("R7", W_CTL, 0);
    tick();

    // R6 shared words in user mode
    cwr(3'd0, 32'h77);
    expect_val("R6", W_VIOL, 0);
    tick();
    crd(3'd0);
    expect_val("R6", W_CTL, 32'h77);
    tick();
    cwr(3'd7, 32'h88);
    tick();
    crd(3'd7);
    expect_val("R6", W_CTL, 32'h88); expect_val("R6", W_VIOL, 0);
    tick();

    // R8 user status write keeps flags
    cwr(3'd1, 32'h0000_00F0);
    tick();
    crd(3'd1); gwr(4'd5, 32'h5555);
    expect_val("R8", W_CTL, 32'h2000_00F0);
    expect_val("R8", W_PRIV, 0); expect_val("R8", W_BANK, 1);
    tick();

    // R10 exception overrides a same-cycle status write
    exc_take_i = 1'b1; cwr(3'd1, 32'h0);
    tick();
    crd(3'd1); rd_a_idx_i = 4'd3;
    expect_val("R10", W_PRIV, 1); expect_val("R10", W_BANK, 1);
    expect_val("R10", W_CTL, 32'h6000_00F0);
    expect_val("R4", W_RDA, 32'hA1);
    tick();
    ard(3'd3); rd_b_idx_i = 4'd5;
    expect_val("R4", W_ALT, 32'h33); expect_val("R2", W_RDB, 0);
    tick();
    ard(3'd5); crd(3'd2);
    expect_val("R4", W_ALT, 32'h5555); expect_val("R7", W_CTL, 32'h55);
    tick();

    // R11 on port B for a shared index
    gwr(4'd9, 32'h99); rd_b_idx_i = 4'd9;
    expect_val("R11", W_RDB, 0);
    tick();
    rd_b_idx_i = 4'd9;
    expect_val("R11", W_RDB, 32'h99);
    tick();

    @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule